// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a two-port synchronous RAM whose address space is cut into four equal banks. Each bank belongs to exactly one of the two ports at any moment. Four static select inputs set the owner, one input per bank. Each port has its own active-low chip enable, an active-low write strobe, an address and a data bus. Only the port that owns a bank can change that bank's contents or read them back. When a port writes to a bank it does not own, nothing happens. When it reads such a bank, it receives a fixed filler word.

The system sets the bank selects to hand regions of memory from one processor to the other. Ownership changes only while both ports are write-disabled. A sticky flag records any select change made while a write strobe was active on either port. Reset is the only way to clear it.

Top module: `bank_dual_port_ram`

## Requirements
- R1: The bank number of an address is its two most significant bits, so the banks are equal and contiguous. With the default 6-bit address, bank 0 covers 0x00-0x0F and bank 3 covers 0x30-0x3F.
- R2: Bank select bit b at 1 gives bank b to the left port. At 0 it gives bank b to the right port.
- R3: A write happens at the clock edge where a port has chip enable low and the write strobe low, and the port owns the addressed bank. A read (chip enable low, write strobe high) of an owned bank returns the stored word on that port's read data output after the next rising clock edge.
- R4: A write by a port to a bank it does not own leaves the memory unchanged. Reading the location through the owning port shows this.
- R5: A read by a port from a bank it does not own returns the filler word, which is 16'h0000 by default, after the next clock edge.
- R6: One port may own any number of banks, from none to all four, and the other port owns the rest.
- R7: A cycle in which chip enable is high writes nothing, even when the write strobe is low.
- R8: A port's read data output holds its last value in every cycle in which that port issues no read.
- R9: The select-error flag is set at the first clock edge at which the bank select value differs from its value at the previous edge while either port has chip enable and write strobe both low. Once set, it stays set until reset.
- R10: Changing the bank selects while both ports are write-disabled leaves the select-error flag clear.
- R11: Synchronous active-high reset clears both read data outputs to the filler word and clears the select-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 4 | Per-bank owner select, 1 = left, 0 = right |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W (6) | Left address, top two bits pick the bank |
| l_wdata | input | DATA_W (16) | Left write data |
| l_rdata | output | DATA_W (16) | Left registered read data |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W (6) | Right address, top two bits pick the bank |
| r_wdata | input | DATA_W (16) | Right write data |
| r_rdata | output | DATA_W (16) | Right registered read data |
| sel_err | output | 1 | Sticky flag: selects changed during an active write |

## Verification
Several properties are checked on every cycle:
- The two ports never both write into the same bank.
- A read of an unowned bank yields the filler word.
- Read data holds steady in cycles with no read.
- The select-error flag never clears on its own, and it rises only after a select change that came with an active write.

Other behaviours show up only in the bench's scenarios:
- Stored data comes back correctly at the edges of each bank.
- A rejected write really left the owner's data intact.
- Handing all banks to one side and then to the other moves access as expected.
- The flag stays clear after select changes made while the ports were write-disabled.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_IDX_W = 2;

  typedef logic [BANK_IDX_W-1:0] bank_idx_t;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/bsdp_owner.sv
module bsdp_owner
  import bsdp_pkg::*;
#(
  parameter side_e SIDE = SIDE_LEFT
) (
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  bank_idx_t            bank,
  output logic                 owns
);
  // R2: a high select hands the bank to the left side
  generate
    if (SIDE == SIDE_LEFT) begin : g_left
      assign owns = bank_sel[bank];
    end else begin : g_right
      assign owns = ~bank_sel[bank];
    end
  endgenerate
endmodule

// File: rtl/bsdp_dp_mem.sv
module bsdp_dp_mem
  import bsdp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en [2],
  input  logic              rd_en [2],
  input  logic [ADDR_W-1:0] addr  [2],
  input  logic [DATA_W-1:0] wdata [2],
  output logic [DATA_W-1:0] rdata [2]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
      if (rd_en[p]) rdata[p] <= mem[addr[p]];
    end
  end

  // R2: exclusive ownership means the two write ports never hit the same bank
  a_r2_single_writer_per_bank: assert property (@(posedge clk) disable iff (rst)
    !(wr_en[0] && wr_en[1] &&
      addr[0][ADDR_W-1 -: BANK_IDX_W] == addr[1][ADDR_W-1 -: BANK_IDX_W]));
endmodule

// File: rtl/bsdp_port.sv
module bsdp_port
  import bsdp_pkg::*;
#(
  parameter side_e             SIDE      = SIDE_LEFT,
  parameter int                ADDR_W    = 6,
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] FILL_WORD = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  logic                 ce_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 wr_en,
  output logic                 rd_en,
  output logic [DATA_W-1:0]    rdata
);
  bank_idx_t bank;
  logic      owns;
  logic      rd_req;
  logic      owned_q;

  assign bank = addr[ADDR_W-1 -: BANK_IDX_W];  // R1

  bsdp_owner #(.SIDE(SIDE)) u_owner (
    .bank_sel (bank_sel),
    .bank     (bank),
    .owns     (owns)
  );

  assign rd_req = ~ce_n & we_n;
  assign wr_en  = ~ce_n & ~we_n & owns;  // R4, R7
  assign rd_en  = rd_req & owns;

  always_ff @(posedge clk) begin
    if (rst)         owned_q <= 1'b0;
    else if (rd_req) owned_q <= owns;
  end

  assign rdata = owned_q ? mem_rdata : FILL_WORD;  // R5, R11

  a_r5_foreign_read_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !owns) |=> (rdata == FILL_WORD));

  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rdata));
endmodule

// File: rtl/bsdp_sel_watch.sv
module bsdp_sel_watch
  import bsdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  logic                 wr_any,
  output logic                 sel_err
);
  logic [NUM_BANKS-1:0] sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= bank_sel;
      sel_err  <= 1'b0;
    end else begin
      sel_prev <= bank_sel;
      if (wr_any && (bank_sel != sel_prev)) sel_err <= 1'b1;  // R9
    end
  end

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err);

  a_r9_flag_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_err) |-> $past(wr_any));
endmodule

// File: rtl/bank_dual_port_ram.sv
module bank_dual_port_ram
  import bsdp_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                BANK_DEPTH = 16,
  parameter logic [DATA_W-1:0] FILL_WORD  = '0,
  localparam int               OFF_W      = $clog2(BANK_DEPTH),
  localparam int               ADDR_W     = OFF_W + BANK_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  logic                 l_ce_n,
  input  logic                 l_we_n,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  input  logic                 r_ce_n,
  input  logic                 r_we_n,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata,
  output logic                 sel_err
);
  logic              ce_n_a  [2];
  logic              we_n_a  [2];
  logic [ADDR_W-1:0] addr_a  [2];
  logic [DATA_W-1:0] wdata_a [2];
  logic [DATA_W-1:0] mrd_a   [2];
  logic [DATA_W-1:0] rdata_a [2];
  logic              wr_en_a [2];
  logic              rd_en_a [2];

  assign ce_n_a[0]  = l_ce_n;
  assign ce_n_a[1]  = r_ce_n;
  assign we_n_a[0]  = l_we_n;
  assign we_n_a[1]  = r_we_n;
  assign addr_a[0]  = l_addr;
  assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;
  assign wdata_a[1] = r_wdata;
  assign l_rdata    = rdata_a[0];
  assign r_rdata    = rdata_a[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    bsdp_port #(
      .SIDE      ((p == 0) ? SIDE_LEFT : SIDE_RIGHT),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FILL_WORD (FILL_WORD)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .bank_sel  (bank_sel),
      .ce_n      (ce_n_a[p]),
      .we_n      (we_n_a[p]),
      .addr      (addr_a[p]),
      .mem_rdata (mrd_a[p]),
      .wr_en     (wr_en_a[p]),
      .rd_en     (rd_en_a[p]),
      .rdata     (rdata_a[p])
    );
  end

  bsdp_dp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en_a),
    .rd_en (rd_en_a),
    .addr  (addr_a),
    .wdata (wdata_a),
    .rdata (mrd_a)
  );

  bsdp_sel_watch u_watch (
    .clk      (clk),
    .rst      (rst),
    .bank_sel (bank_sel),
    .wr_any   ((~l_ce_n & ~l_we_n) | (~r_ce_n & ~r_we_n)),
    .sel_err  (sel_err)
  );
endmodule

// File: tb/test_bank_dual_port_ram.sv
module test_bank_dual_port_ram;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bank_sel = 4'b0011;
  logic          l_ce_n = 1'b1, l_we_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          sel_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    bit          side;
    logic [DW-1:0] exp;
    int          cyc;
    string       req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  bank_dual_port_ram i_bank_dual_port_ram (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .sel_err(sel_err)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    l_ce_n = 1'b1; l_we_n = 1'b1;
    r_ce_n = 1'b1; r_we_n = 1'b1;
  endtask

  task automatic drive(bit side, bit ce_n, bit we_n, logic [AW-1:0] a, logic [DW-1:0] d);
    if (!side) begin l_ce_n = ce_n; l_we_n = we_n; l_addr = a; l_wdata = d; end
    else       begin r_ce_n = ce_n; r_we_n = we_n; r_addr = a; r_wdata = d; end
  endtask

  task automatic wr(bit side, logic [AW-1:0] a, logic [DW-1:0] d);
    drive(side, 1'b0, 1'b0, a, d);
    tick();
    idle();
  endtask

  task automatic push_rd(bit side, logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    item_t it;
    drive(side, 1'b0, 1'b1, a, '0);
    it.side = side; it.exp = exp; it.cyc = cyc; it.req = req;
    q.push_back(it);
  endtask

  task automatic rd(bit side, logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    push_rd(side, a, exp, req);
    tick();
    idle();
  endtask

  // monitor: each read is compared after the edge that captured it
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc + 1 == cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.req, it.side ? r_rdata : l_rdata, it.exp);
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11: reset state
    chk("R11 l_rdata", l_rdata, 16'h0000);
    chk("R11 r_rdata", r_rdata, 16'h0000);
    chk("R11 sel_err", {15'd0, sel_err}, 16'h0000);
    rst = 1'b0;
    tick();

    // left owns banks 0,1; right owns 2,3 (R2)
    wr(0, 6'h01, 16'hA001);
    wr(0, 6'h1F, 16'hA01F);
    wr(1, 6'h20, 16'hB020);
    wr(1, 6'h3F, 16'hB03F);
    rd(0, 6'h01, 16'hA001, "R3 left owned read");
    rd(0, 6'h1F, 16'hA01F, "R1 bank1 top word");
    rd(1, 6'h20, 16'hB020, "R1 bank2 first word");
    push_rd(0, 6'h01, 16'hA001, "R3 dual read left");
    push_rd(1, 6'h3F, 16'hB03F, "R3 dual read right");
    tick(); idle();
    rd(0, 6'h20, 16'h0000, "R5 left foreign read");
    rd(1, 6'h05, 16'h0000, "R5 right foreign read");

    // R4: foreign write leaves owner's data
    wr(1, 6'h21, 16'h1234);
    wr(0, 6'h21, 16'hDEAD);
    rd(1, 6'h21, 16'h1234, "R4 foreign write ignored");

    // R7: chip enable high blocks the write
    drive(0, 1'b1, 1'b0, 6'h01, 16'h5555);
    tick(); idle();
    rd(0, 6'h01, 16'hA001, "R7 write without enable");

    // R8: output holds without reads
    repeat (3) tick();
    chk("R8 left hold", l_rdata, 16'hA001);
    chk("R8 right hold", r_rdata, 16'h1234);

    // R6: left owns all banks
    bank_sel = 4'b1111;
    tick();
    rd(0, 6'h20, 16'hB020, "R6 left owns all");
    rd(0, 6'h3F, 16'hB03F, "R6 left owns all top");
    rd(1, 6'h20, 16'h0000, "R6 right owns none");
    // R6: right owns all banks
    bank_sel = 4'b0000;
    tick();
    rd(1, 6'h01, 16'hA001, "R6 right owns all");
    rd(0, 6'h01, 16'h0000, "R6 left owns none");
    bank_sel = 4'b0101;
    tick();
    rd(0, 6'h20, 16'hB020, "R2 mixed select bank2 left");
    rd(1, 6'h1F, 16'hA01F, "R2 mixed select bank1 right");
    tick();
    chk("R10 flag clear after idle changes", {15'd0, sel_err}, 16'h0000);

    // R9: select change during an active write
    drive(0, 1'b0, 1'b0, 6'h02, 16'h7777);
    bank_sel = 4'b0111;
    tick(); idle();
    #8;
    chk("R9 flag set", {15'd0, sel_err}, 16'h0001);
    repeat (3) tick();
    chk("R9 flag sticky", {15'd0, sel_err}, 16'h0001);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    chk("R9 flag cleared by reset", {15'd0, sel_err}, 16'h0000);

    repeat (2) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule